// File: doc/BRIEF.md
# Boot-Code Execution Domain Guard

This block monitors a small five-stage in-order processor and protects two address regions. One region holds immutable boot code. The other is a small read-only store that holds a 256-bit device secret. The guard decides whether code is privileged from one fact only: the address the instruction was fetched from. An instruction fetched from inside the boot-code region gets an in-boot tag. That tag moves with the instruction through the decode, execute and memory stages. It gates three things: reads of the secret, the interrupt unit and the debug unit.

The guard also keeps control from entering the boot code from outside. The core starts fetching inside the boot region after reset. Once any fetch outside that region has been accepted, a sticky exit flag is set and stays set until reset. In either of the following cases the guard asks the core to redirect the fetch to its trap vector:
- the fetch would move from an outside address to an inside one;
- the fetch targets the boot region while the exit flag is set.

A secret read made by an instruction whose memory-stage tag is clear is blocked. In the same cycle the guard raises a memory trap and forces the returned data to zero.

Top module: `bootdom_guard`

## Requirements
- R1: After a synchronous reset the three stage tags (decode, execute, memory) are zero, the exit flag is clear, and the interrupt and debug enables are high.
- R2: When `pipe_adv` is high and `pipe_flush` is low, the tags shift on the clock edge. Decode takes `fetch_valid` AND (fetch_pc inside the boot region), execute takes the old decode tag, and memory takes the old execute tag. When `pipe_adv` is low and there is no flush, all tags hold.
- R3: Before exit, `fetch_trap` is high exactly when `fetch_valid` is high, `fetch_next_pc` is inside the boot region and `fetch_pc` is outside it. This holds even when the fetch is not accepted. Inside-to-inside and anything-to-outside moves do not trap.
- R4: The first accepted fetch (`fetch_valid` and `pipe_adv`) whose `fetch_pc` lies outside the boot region sets the exit flag, and only reset clears it. While the flag is set, every valid fetch whose next address is inside the boot region traps, including an inside-to-inside fall-through.
- R5: A read (`mem_valid` and `mem_read`) that touches the secret region while the memory-stage tag is 0 raises `mem_trap` in the same cycle and drives `mem_rdata_out` to zero.
- R6: A secret read with the memory-stage tag at 1, any write, and any read that misses the secret region all pass `mem_rdata_in` through unchanged, with `mem_trap` low.
- R7: An access covers 2^`mem_size` bytes starting at `mem_addr` (0 = byte, 1 = half, 2 = word). It touches the secret region if any of those bytes falls in [SECRET_BASE, SECRET_BASE+SECRET_BYTES). So a word that starts below the base but reaches into it is blocked, a word that ends right at the base is not, the byte at base+31 is blocked, and the byte at base+32 is not.
- R8: `irq_enable` and `dbg_enable` both equal the inverse of the decode-stage tag.
- R9: On `pipe_flush` the decode and execute tags become 0. The memory tag takes the old execute tag if `pipe_adv` is high, and holds otherwise.
- R10: The boot region test takes the base as inclusive and base + BOOT_BYTES as exclusive, for both the current and the next fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch stage holds a valid instruction |
| fetch_pc | input | AW | Address of the instruction being fetched |
| fetch_next_pc | input | AW | Address the next fetch will use |
| pipe_adv | input | 1 | All stages advance on this edge |
| pipe_flush | input | 1 | Squash the decode and execute stages |
| mem_valid | input | 1 | Memory stage issues a data access |
| mem_read | input | 1 | High for a read, low for a write |
| mem_addr | input | AW | Start address of the data access |
| mem_size | input | 2 | log2 of the access length in bytes |
| mem_rdata_in | input | DW | Read data from the memory system |
| mem_rdata_out | output | DW | Read data after secret filtering |
| mem_trap | output | 1 | Blocked secret read, raise a memory trap |
| fetch_trap | output | 1 | Redirect the next fetch to the trap vector |
| stage_tags | output | 3 | In-boot tags {memory, execute, decode} |
| irq_enable | output | 1 | Interrupt unit enable |
| dbg_enable | output | 1 | Debug unit enable |

## Verification
The bench targets the edges of both regions. A design with an off-by-one base or limit would trap on the last boot instruction's exit, or would leak the byte just below or at the end of the secret. It also checks an unaligned word that straddles the secret base: a start-address-only check would let that word through.

It checks that re-entry by fall-through still traps after exit, and that a second reset clears the exit flag. A flag that was never made sticky, or that outlives reset, fails one of these two checks. Flushes are issued while boot-tagged instructions sit in the pipe, so a squashed bubble that kept its tag would show up as a stale enable or a granted secret read.

// File: rtl/bootdom_pkg.sv
package bootdom_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_DBL  = 2'd3
  } acc_size_e;

  function automatic logic [3:0] acc_bytes(acc_size_e s);
    return 4'd1 << s;
  endfunction
endpackage

// File: rtl/bootdom_region_cmp.sv
module bootdom_region_cmp #(
  parameter int unsigned AW    = 32,
  parameter longint unsigned BASE  = 64'h8000,
  parameter longint unsigned BYTES = 4096
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + BYTES);

  always_comb hit = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
endmodule

// File: rtl/bootdom_span_overlap.sv
module bootdom_span_overlap #(
  parameter int unsigned AW    = 32,
  parameter longint unsigned BASE  = 64'h10000,
  parameter longint unsigned BYTES = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output logic          hit
);
  import bootdom_pkg::*;
  localparam logic [AW:0] LO = (AW+1)'(BASE);
  localparam logic [AW:0] HI = (AW+1)'(BASE + BYTES);

  logic [AW:0] span_end;
  always_comb begin
    span_end = {1'b0, addr} + {{(AW-3){1'b0}}, acc_bytes(acc_size_e'(size))};
    hit      = ({1'b0, addr} < HI) && (span_end > LO);
  end
endmodule

// File: rtl/bootdom_tag_pipe.sv
module bootdom_tag_pipe #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned KILL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              flush,
  input  logic              tag_in,
  output logic [STAGES-1:0] tags
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic src;
    if (i == 0) begin : g_head
      assign src = tag_in;
    end else begin : g_body
      assign src = tags[i-1];
    end
    always_ff @(posedge clk) begin
      if (rst)                      tags[i] <= 1'b0;
      else if (flush && i < KILL)   tags[i] <= 1'b0;
      else if (adv)                 tags[i] <= src;
    end
  end
endmodule

// File: rtl/bootdom_guard.sv
module bootdom_guard #(
  parameter int unsigned     AW           = 32,
  parameter int unsigned     DW           = 32,
  parameter longint unsigned BOOT_BASE    = 64'h0000_8000,
  parameter longint unsigned BOOT_BYTES   = 4096,
  parameter longint unsigned SECRET_BASE  = 64'h0001_0000,
  parameter longint unsigned SECRET_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_pc,
  input  logic [AW-1:0] fetch_next_pc,
  input  logic          pipe_adv,
  input  logic          pipe_flush,
  input  logic          mem_valid,
  input  logic          mem_read,
  input  logic [AW-1:0] mem_addr,
  input  logic [1:0]    mem_size,
  input  logic [DW-1:0] mem_rdata_in,
  output logic [DW-1:0] mem_rdata_out,
  output logic          mem_trap,
  output logic          fetch_trap,
  output logic [2:0]    stage_tags,
  output logic          irq_enable,
  output logic          dbg_enable
);
  localparam int unsigned N_STAGES = 3;
  localparam int unsigned N_KILL   = 2;
  localparam int unsigned MEM_IDX  = N_STAGES - 1;

  logic cur_in_boot, next_in_boot, secret_touch, exited_q;

  bootdom_region_cmp #(.AW(AW), .BASE(BOOT_BASE), .BYTES(BOOT_BYTES)) cur_cmp_i (
    .addr(fetch_pc), .hit(cur_in_boot));

  bootdom_region_cmp #(.AW(AW), .BASE(BOOT_BASE), .BYTES(BOOT_BYTES)) next_cmp_i (
    .addr(fetch_next_pc), .hit(next_in_boot));

  bootdom_span_overlap #(.AW(AW), .BASE(SECRET_BASE), .BYTES(SECRET_BYTES)) sec_ovl_i (
    .addr(mem_addr), .size(mem_size), .hit(secret_touch));

  bootdom_tag_pipe #(.STAGES(N_STAGES), .KILL(N_KILL)) tags_i (
    .clk(clk), .rst(rst), .adv(pipe_adv), .flush(pipe_flush),
    .tag_in(fetch_valid && cur_in_boot), .tags(stage_tags));

  // sticky exit: set by the first accepted fetch outside the boot code
  always_ff @(posedge clk) begin
    if (rst)
      exited_q <= 1'b0;
    else if (fetch_valid && pipe_adv && !cur_in_boot)
      exited_q <= 1'b1;
  end

  always_comb begin
    fetch_trap    = fetch_valid && next_in_boot && (!cur_in_boot || exited_q);
    mem_trap      = mem_valid && mem_read && secret_touch && !stage_tags[MEM_IDX];
    mem_rdata_out = mem_trap ? '0 : mem_rdata_in;
    irq_enable    = !stage_tags[0];
    dbg_enable    = !stage_tags[0];
  end
endmodule

// File: rtl/bootdom_guard_sva.sv
module bootdom_guard_sva #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          fetch_valid,
  input logic          pipe_adv,
  input logic          pipe_flush,
  input logic          cur_in_boot,
  input logic          next_in_boot,
  input logic          exited_q,
  input logic          fetch_trap,
  input logic          mem_trap,
  input logic [DW-1:0] mem_rdata_out,
  input logic [2:0]    stage_tags,
  input logic          irq_enable,
  input logic          dbg_enable
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stage_tags == 3'b000 && !exited_q));

  assert_tag_shift_R2: assert property (@(posedge clk) disable iff (rst)
    (pipe_adv && !pipe_flush) |=> (stage_tags[2] == $past(stage_tags[1])));

  assert_entry_trap_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && next_in_boot && !cur_in_boot) |-> fetch_trap);

  assert_exit_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    exited_q |=> exited_q);

  assert_reentry_trap_R4: assert property (@(posedge clk) disable iff (rst)
    (exited_q && fetch_valid && next_in_boot) |-> fetch_trap);

  assert_blocked_zero_R5: assert property (@(posedge clk) disable iff (rst)
    mem_trap |-> (mem_rdata_out == '0));

  assert_enables_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_enable == dbg_enable) && (stage_tags[0] != irq_enable));

  assert_flush_kill_R9: assert property (@(posedge clk) disable iff (rst)
    pipe_flush |=> (stage_tags[1:0] == 2'b00));
endmodule

bind bootdom_guard bootdom_guard_sva #(.DW(DW)) sva_i (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .pipe_adv(pipe_adv),
  .pipe_flush(pipe_flush), .cur_in_boot(cur_in_boot), .next_in_boot(next_in_boot),
  .exited_q(exited_q), .fetch_trap(fetch_trap), .mem_trap(mem_trap),
  .mem_rdata_out(mem_rdata_out), .stage_tags(stage_tags),
  .irq_enable(irq_enable), .dbg_enable(dbg_enable));

// File: tb/bootdom_guard_tb_top.sv
`timescale 1ns/1ps
module bootdom_guard_tb_top;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam longint unsigned BB = 64'h0000_8000;
  localparam longint unsigned BS = 4096;
  localparam longint unsigned SB = 64'h0001_0000;
  localparam longint unsigned SS = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fetch_valid = 0, pipe_adv = 0, pipe_flush = 0;
  logic mem_valid = 0, mem_read = 0;
  logic [AW-1:0] fetch_pc = '0, fetch_next_pc = '0, mem_addr = '0;
  logic [1:0] mem_size = '0;
  logic [DW-1:0] mem_rdata_in = '0, mem_rdata_out;
  logic mem_trap, fetch_trap, irq_enable, dbg_enable;
  logic [2:0] stage_tags;

  always #5 clk = ~clk;

  bootdom_guard #(.AW(AW), .DW(DW), .BOOT_BASE(BB), .BOOT_BYTES(BS),
                  .SECRET_BASE(SB), .SECRET_BYTES(SS)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_next_pc(fetch_next_pc), .pipe_adv(pipe_adv), .pipe_flush(pipe_flush),
    .mem_valid(mem_valid), .mem_read(mem_read), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_rdata_in(mem_rdata_in), .mem_rdata_out(mem_rdata_out),
    .mem_trap(mem_trap), .fetch_trap(fetch_trap), .stage_tags(stage_tags),
    .irq_enable(irq_enable), .dbg_enable(dbg_enable));

  int checks = 0, errors = 0;
  string req = "R1";
  bit done = 0;
  bit m_dec = 0, m_ex = 0, m_mem = 0, m_exit = 0;

  function automatic bit in_boot(longint unsigned a);
    return a >= BB && a < BB + BS;
  endfunction

  function automatic bit touches(longint unsigned a, int unsigned sz);
    longint unsigned n = 64'd1 << sz;
    return a < SB + SS && a + n > SB;
  endfunction

  task automatic chk(string r, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // reference model state update
  always @(posedge clk) begin
    if (rst) begin
      m_dec = 0; m_ex = 0; m_mem = 0; m_exit = 0;
    end else begin
      if (fetch_valid && pipe_adv && !in_boot(fetch_pc)) m_exit = 1;
      if (pipe_flush) begin
        if (pipe_adv) m_mem = m_ex;
        m_ex = 0; m_dec = 0;
      end else if (pipe_adv) begin
        m_mem = m_ex; m_ex = m_dec; m_dec = fetch_valid && in_boot(fetch_pc);
      end
    end
  end

  task automatic compare_all();
    bit ft, mt;
    ft = fetch_valid && in_boot(fetch_next_pc) && (!in_boot(fetch_pc) || m_exit);
    mt = mem_valid && mem_read && touches(mem_addr, mem_size) && !m_mem;
    chk(req, "fetch_trap", fetch_trap, ft);
    chk(req, "mem_trap", mem_trap, mt);
    chk(req, "rdata", mem_rdata_out, mt ? 0 : mem_rdata_in);
    chk(req, "tags", stage_tags, {m_mem, m_ex, m_dec});
    chk(req, "irq_en", irq_enable, !m_dec);
    chk(req, "dbg_en", dbg_enable, !m_dec);
  endtask

  task automatic step(input longint unsigned pc, input longint unsigned npc,
                      input bit fv, input bit adv, input bit fl);
    @(negedge clk);
    fetch_pc = AW'(pc); fetch_next_pc = AW'(npc);
    fetch_valid = fv; pipe_adv = adv; pipe_flush = fl;
    #1;
    if (!rst) compare_all();
  endtask

  task automatic access(input longint unsigned a, input int unsigned sz, input bit rd);
    @(negedge clk);
    mem_valid = 1; mem_read = rd; mem_addr = AW'(a); mem_size = 2'(sz);
    mem_rdata_in = 32'hA5C3_0000 | 32'(a[15:0]);
    pipe_adv = 0; pipe_flush = 0;
    #1;
    compare_all();
    @(negedge clk);
    mem_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    fetch_valid = 0; pipe_adv = 0; pipe_flush = 0; mem_valid = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    #1;
    req = "R1";
    chk("R1", "tags after reset", stage_tags, 0);
    chk("R1", "irq after reset", irq_enable, 1);
    chk("R1", "dbg after reset", dbg_enable, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // boot code runs, tags propagate
    req = "R2";
    for (int i = 0; i < 4; i++) step(BB + 4*i, BB + 4*i + 4, 1, 1, 0);
    req = "R8";
    step(BB + 16, BB + 20, 1, 0, 0);
    req = "R2";
    step(BB + 16, BB + 20, 1, 0, 0);
    req = "R6";
    access(SB, 2, 1);
    access(SB + 28, 2, 1);
    // flush with boot instructions in flight
    req = "R9";
    step(BB + 16, BB + 20, 1, 1, 1);
    step(BB + 20, BB + 24, 0, 0, 1);
    step(BB + 20, BB + 24, 1, 1, 0);
    // not-accepted outside fetch probing entry at base (inclusive)
    req = "R3";
    step(BB - 4, BB, 1, 0, 0);
    req = "R10";
    step(BB - 1, BB - 1, 1, 0, 0);
    step(BB + BS - 4, BB + BS - 1, 1, 0, 0);
    // leave the boot code across the limit (exclusive)
    step(BB + BS - 4, BB + BS, 1, 1, 0);
    req = "R4";
    step(BB + BS, BB + BS + 4, 1, 1, 0);
    for (int i = 0; i < 3; i++) step(BB + BS + 8 + 4*i, BB + BS + 12 + 4*i, 1, 1, 0);
    step(BB + BS + 40, BB, 1, 0, 0);
    step(BB + 8, BB + 12, 1, 0, 0);
    step(BB + BS + 40, BB + BS - 4, 1, 0, 0);
    step(BB + BS + 40, BB + BS + 44, 1, 1, 0);
    // secret reads from outside code
    req = "R5";
    access(SB, 2, 1);
    access(SB + 8, 0, 1);
    req = "R7";
    access(SB - 2, 2, 1);
    access(SB - 4, 2, 1);
    access(SB - 1, 1, 1);
    access(SB + SS - 1, 0, 1);
    access(SB + SS, 0, 1);
    access(SB + SS - 2, 2, 1);
    req = "R6";
    access(SB, 2, 0);
    access(64'h0000_2000, 2, 1);
    // second reset clears exit
    do_reset();
    req = "R4";
    step(BB, BB + 4, 1, 1, 0);
    step(BB + 4, BB + 8, 1, 1, 0);
    req = "R3";
    step(BB + 8, BB + BS + 8, 1, 0, 0);
    step(BB + BS + 8, BB + 12, 1, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule